// File: doc/BRIEF.md
# Serial-Chain Bus Grant Arbiter

This block shares one bus among a parameterised number of devices. Every device drives a common request line, and the central grant source sees only the OR of those requests. One cycle after that combined request goes high, the grant source raises a single grant. The grant enters device position 0 and moves combinationally from cell to cell. Each cell passes the grant on only while it is neither requesting nor holding the bus. As a result, the requesting device nearest the grant source is the first to see the grant, and it becomes the bus owner on the next clock edge.

Ownership is registered in each cell and lasts until the local master pulses its release input. A shared busy indication stops any cell from seizing the bus while another cell owns it. This applies even when the new requester sits closer to the grant source than the current owner. When the owner releases, the next requester the grant reaches becomes owner. The grant source keeps the grant high for as long as any device is requesting or owning. It removes the grant one cycle after the combined request falls. A synchronous active-high reset clears all ownership and the grant.

Top module: `dc_bus_arbiter`

## Requirements
- R1: During and after a synchronous reset, every `owner` bit and `bus_grant` read 0 until a request is raised.
- R2: `bus_grant` goes to 1 one cycle after any device has `req_in` high or holds ownership. It goes to 0 one cycle after no device does either.
- R3: `chain_end` is 1 exactly when `bus_grant` is 1 and no device has `req_in` high or holds ownership, so the grant has passed every cell.
- R4: When no device owns the bus and `bus_grant` is 1, the requesting device with the lowest index becomes owner at the next clock edge.
- R5: At most one bit of `owner` is 1 in any cycle.
- R6: An owner stays owner while its `done` bit is 0, even if it drops its `req_in`.
- R7: A 1 on the owner's `done` bit clears its ownership at the next edge. On the following edge, the lowest-index device still requesting becomes owner.
- R8: A device that raises `req_in` while another device owns the bus does not become owner before that owner releases, even when its index is lower.
- R9: A `done` pulse on a device that is not the owner has no effect on `owner`.
- R10: A device that keeps its request raised becomes owner within three cycles after the last lower-index requester releases and stops requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N_DEV | Bus request per device, index 0 nearest the grant source |
| done | input | N_DEV | Release pulse per device from its local master |
| owner | output | N_DEV | Registered bus-ownership flag per device |
| bus_grant | output | 1 | Registered grant driven into position 0 of the chain |
| chain_end | output | 1 | Grant leaving the last cell of the chain |

## Verification
Directed sequences use two requesters that are far apart, which shows whether the lower index wins at the grant. A closer device then requests while the bus is held, which separates proper blocking from stealing. The owner then drops its request without `done`, which shows whether ownership is tied to the release pulse and not to the request level. Stray `done` pulses on non-owners, and a single remaining far requester, test whether releases are ignored and whether the far device is served. A seeded random phase mixes arrivals, releases and stray pulses over thousands of cycles. Each cycle it is compared with a bench reference model for owner, grant and chain exit.

// File: rtl/dc_pkg.sv
package dc_pkg;
    parameter int unsigned DC_NUM_DEV_DEFAULT = 4;

    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_OWNS = 1'b1
    } cell_state_e;

    typedef struct packed {
        logic want;
        logic release_pulse;
    } cell_in_t;

    function automatic logic cell_blocks(input cell_in_t ci, input cell_state_e st);
        return ci.want || (st == CELL_OWNS);
    endfunction
endpackage

// File: rtl/dc_grant_src.sv
module dc_grant_src (
    input  logic clk,
    input  logic rst,
    input  logic req_any,
    output logic grant
);
    logic grant_q;

    always_ff @(posedge clk) begin
        if (rst) grant_q <= 1'b0;
        else     grant_q <= req_any;
    end

    assign grant = grant_q;

    p_grant_rise_r2: assert property (@(posedge clk) disable iff (rst)
        req_any |=> grant);
    p_grant_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !req_any |=> !grant);
endmodule

// File: rtl/dc_chain_cell.sv
module dc_chain_cell
    import dc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    input  logic done,
    input  logic grant_in,
    input  logic bus_busy,
    output logic grant_out,
    output logic owner,
    output logic bus_req
);
    cell_in_t    cin;
    cell_state_e st_q, st_d;

    assign cin.want          = req_in;
    assign cin.release_pulse = done;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CELL_OWNS: if (cin.release_pulse) st_d = CELL_IDLE;
            CELL_IDLE: if (grant_in && cin.want && !bus_busy) st_d = CELL_OWNS;
            default:   st_d = CELL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CELL_IDLE;
        else     st_q <= st_d;
    end

    assign owner     = (st_q == CELL_OWNS);
    assign bus_req   = cell_blocks(cin, st_q);
    assign grant_out = grant_in && !cell_blocks(cin, st_q);

    p_keep_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (owner && !done) |=> owner);
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (owner && done) |=> !owner);
    p_no_steal_r8: assert property (@(posedge clk) disable iff (rst)
        (!owner && bus_busy) |=> !owner);
endmodule

// File: rtl/dc_bus_arbiter.sv
module dc_bus_arbiter
    import dc_pkg::*;
#(
    parameter int unsigned N_DEV = DC_NUM_DEV_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] req_in,
    input  logic [N_DEV-1:0] done,
    output logic [N_DEV-1:0] owner,
    output logic             bus_grant,
    output logic             chain_end
);
    localparam int unsigned CHAIN_W = N_DEV + 1;

    logic [CHAIN_W-1:0] chain;
    logic [N_DEV-1:0]   dev_req;
    logic [N_DEV-1:0]   own_vec;
    logic               busy;
    logic               req_any;
    logic               grant;

    assign busy    = |own_vec;
    assign req_any = |dev_req;

    dc_grant_src u_src (
        .clk     (clk),
        .rst     (rst),
        .req_any (req_any),
        .grant   (grant)
    );

    assign chain[0] = grant;

    for (genvar g = 0; g < N_DEV; g++) begin : g_cell
        dc_chain_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .req_in    (req_in[g]),
            .done      (done[g]),
            .grant_in  (chain[g]),
            .bus_busy  (busy),
            .grant_out (chain[g+1]),
            .owner     (own_vec[g]),
            .bus_req   (dev_req[g])
        );
    end

    assign owner     = own_vec;
    assign bus_grant = grant;
    assign chain_end = chain[N_DEV];

    p_one_owner_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owner));
    p_win_needs_grant_r4: assert property (@(posedge clk) disable iff (rst)
        ((owner != '0) && ($past(owner) == '0)) |-> $past(bus_grant));
endmodule

// File: tb/dc_bus_arbiter_tb_top.sv
module dc_bus_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req_in;
    logic [N-1:0] done;
    logic [N-1:0] owner;
    logic         bus_grant;
    logic         chain_end;

    int total = 0;
    int bad   = 0;

    logic [N-1:0] m_own;
    logic         m_gnt;

    always #5 clk = ~clk;

    dc_bus_arbiter #(.N_DEV(N)) dut_i (
        .clk(clk), .rst(rst), .req_in(req_in), .done(done),
        .owner(owner), .bus_grant(bus_grant), .chain_end(chain_end)
    );

    function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    function automatic logic [N-1:0] next_owner(input logic [N-1:0] own,
                                                input logic gnt,
                                                input logic [N-1:0] r,
                                                input logic [N-1:0] d);
        if (own != '0) return ((own & d) != '0) ? '0 : own;
        if (gnt) return lowest_bit(r);
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] d);
        @(negedge clk);
        req_in = r;
        done   = d;
        #1;
        chk("R4 owner vs model", owner, m_own);
        chk("R2 grant vs model", {{(N-1){1'b0}}, bus_grant}, {{(N-1){1'b0}}, m_gnt});
        chk("R3 chain exit", {{(N-1){1'b0}}, chain_end},
            {{(N-1){1'b0}}, m_gnt && ((r | m_own) == '0)});
        chk("R5 at most one owner", {{(N-1){1'b0}}, $onehot0(owner)}, {{(N-1){1'b0}}, 1'b1});
        m_gnt = |(r | m_own);
        m_own = next_owner(m_own, m_gnt_prev_hold, r, d);
    endtask

    logic m_gnt_prev_hold;
    always_comb m_gnt_prev_hold = bus_grant;

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] pend;
        logic [N-1:0] d;
        void'($urandom(32'd1234));
        rst = 1'b1; req_in = '0; done = '0;
        m_own = '0; m_gnt = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 owner in reset", owner, '0);
        chk("R1 grant in reset", {{(N-1){1'b0}}, bus_grant}, '0);
        @(negedge clk); rst = 1'b0;
        step(4'b0000, 4'b0000);
        chk("R1 owner after reset", owner, 4'b0000);
        // R4: positions 1 and 3 together
        step(4'b1010, 4'b0000);
        step(4'b1010, 4'b0000);
        chk("R2 grant raised", {{(N-1){1'b0}}, bus_grant}, 4'b0001);
        step(4'b1010, 4'b0000);
        chk("R4 lowest requester wins", owner, 4'b0010);
        // R8: closer device arrives while bus held
        step(4'b1011, 4'b0000);
        step(4'b1011, 4'b0000);
        chk("R8 no steal by closer device", owner, 4'b0010);
        // R6: owner drops request without done
        step(4'b1001, 4'b0000);
        step(4'b1001, 4'b0010);
        chk("R6 owner held without done", owner, 4'b0010);
        step(4'b1001, 4'b0000);
        chk("R7 released after done", owner, 4'b0000);
        step(4'b1001, 4'b0000);
        chk("R7 next requester owns", owner, 4'b0001);
        // R9: stray done on non-owner 3
        step(4'b1001, 4'b1000);
        step(4'b1001, 4'b0000);
        chk("R9 stray done ignored", owner, 4'b0001);
        // R10: far device served after closer one leaves
        step(4'b1000, 4'b0001);
        step(4'b1000, 4'b0000);
        step(4'b1000, 4'b0000);
        chk("R10 far device served", owner, 4'b1000);
        step(4'b0000, 4'b1000);
        step(4'b0000, 4'b0000);
        step(4'b0000, 4'b0000);
        chk("R2 grant removed", {{(N-1){1'b0}}, bus_grant}, 4'b0000);

        pend = '0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            d = '0;
            for (int i = 0; i < N; i++) begin
                if (!pend[i] && ($urandom % 4 == 0)) pend[i] = 1'b1;
                if (m_own[i] && ($urandom % 3 == 0)) begin
                    d[i] = 1'b1;
                    pend[i] = 1'b0;
                end else if (!m_own[i] && ($urandom % 16 == 0)) begin
                    d[i] = 1'b1;
                end
            end
            step(pend, d);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule